// File: doc/BRIEF.md
# Multicycle 8-bit Accumulator Processor Core

This block is a compact processor built around a single 8-bit accumulator. It runs a 12-bit instruction word through a fixed four-state control sequence: it first accepts a program image from an external write port, then repeats fetch, decode and execute, one instruction per pass. Its architectural state is an 8-bit program counter, an 8-bit accumulator, a 4-bit flag register, an 8-bit data register that receives memory reads, and a 12-bit instruction register. It also holds a program store and a 16-word by 8-bit data store.

Instruction formats are picked by a priority decode from the top of the word down. A set bit 11 selects an arithmetic or logic operation between the accumulator and an 8-bit immediate. Otherwise a set bit 10 selects a jump that tests one flag. Otherwise a set bit 9 selects a data-store access. Every remaining word does nothing except advance the program counter. A debug bus shows the control state, PC, accumulator, flags and data register, so a testbench can compare the architectural state after each instruction.

Top module: `acc_cpu`

## Requirements
- R1: While rst_n is low, and right after it is asserted (asynchronously), the state is LOAD (code 0) and PC, Acc, SR and DR all read zero.
- R2: In LOAD, each cycle with load_en and load_we high writes load_data into program address load_addr, and the core stays in LOAD. The first edge that sees load_en low moves it to FETCH (code 1) with PC = 0.
- R3: After LOAD, the state goes FETCH (1) → DECODE (2) → EXECUTE (3) → FETCH, one cycle each. Architectural registers other than IR change only at the end of EXECUTE.
- R4: A word with IR[11]=1 writes Acc with an operation on Acc and the immediate IR[7:0], selected by IR[10:8]: 000 Acc+imm, 001 Acc−imm, 010 Acc unchanged, 011 imm, 100 AND, 101 OR, 110 XOR, 111 imm−Acc.
- R5: An ALU instruction sets SR = {Z, C, S, O} (bit 3 to bit 0). Z is set when the result is zero and S is result bit 7. C is the carry out for addition and the borrow for both subtractions. O is signed overflow for addition and both subtractions. C and O are 0 for moves and logic operations.
- R6: SR changes only when an ALU instruction executes.
- R7: A word with IR[11:10]=01 is a jump that tests the flag chosen by IR[9:8] (00 Z, 01 C, 10 S, 11 O). If that flag is set, PC becomes IR[7:0]; if not, PC becomes PC+1.
- R8: A word with IR[11:9]=001 accesses data address IR[3:0]. With IR[8]=0 it loads that word into DR; with IR[8]=1 it stores Acc there. Acc and SR are unchanged.
- R9: Any word with IR[11:9]=000, including all zeros, only advances PC by one.
- R10: Outside LOAD, load_en and load_we are ignored: the program store is not written and the core does not return to LOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Hold high to stay in the program-load state |
| load_we | input | 1 | Program word write strobe, used in the load state only |
| load_addr | input | 8 | Program store address for the write |
| load_data | input | 12 | Program word to write |
| dbg_state | output | 2 | Control state: 0 load, 1 fetch, 2 decode, 3 execute |
| dbg_pc | output | 8 | Program counter |
| dbg_acc | output | 8 | Accumulator |
| dbg_sr | output | 4 | Flags {Z, C, S, O} |
| dbg_dr | output | 8 | Data register |

## Verification
The bound checker checks these on every cycle: the state order, leaving LOAD with PC at zero, Z and S agreeing with the accumulator after each ALU step, the flags holding across non-ALU steps, jump targets against the tested flag, and Acc and SR holding across memory and no-op steps. The bench's trace program is what shows the exact results of each ALU mode, carry and borrow, signed overflow, a store followed by a read-back through DR, and the rejection of a program write attempted during execution. None of these can be seen in one cycle from the ports.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int DATA_W  = 8;
    localparam int INSTR_W = 12;
    localparam int FLAG_W  = 4;

    // flag register bit positions
    localparam int FLG_Z = 3;
    localparam int FLG_C = 2;
    localparam int FLG_S = 1;
    localparam int FLG_O = 0;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_DECODE = 2'd2,
        ST_EXEC   = 2'd3
    } cpu_state_e;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MOVA = 3'd2,
        OP_MOVI = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_SUBR = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        K_NOP   = 3'd0,
        K_ALU   = 3'd1,
        K_JUMP  = 3'd2,
        K_LOAD  = 3'd3,
        K_STORE = 3'd4
    } instr_kind_e;

    typedef struct packed {
        cpu_state_e           st;
        logic [DATA_W-1:0]    pc;
        logic [DATA_W-1:0]    acc;
        logic [DATA_W-1:0]    dr;
        logic [FLAG_W-1:0]    sr;
        logic [INSTR_W-1:0]   ir;
    } core_regs_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e          op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     y,
    output logic [3:0]       flags
);
    localparam int MSB = W - 1;

    logic [W:0] wide;
    logic       cy;
    logic       ov;

    always_comb begin
        wide = '0;
        cy   = 1'b0;
        ov   = 1'b0;
        unique case (op)
            OP_ADD: begin
                wide = {1'b0, a} + {1'b0, b};
                cy   = wide[W];
                ov   = (a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]);
            end
            OP_SUB: begin
                wide = {1'b0, a} - {1'b0, b};
                cy   = wide[W];
                ov   = (a[MSB] != b[MSB]) && (wide[MSB] != a[MSB]);
            end
            OP_SUBR: begin
                wide = {1'b0, b} - {1'b0, a};
                cy   = wide[W];
                ov   = (a[MSB] != b[MSB]) && (wide[MSB] != b[MSB]);
            end
            OP_MOVA: wide = {1'b0, a};
            OP_MOVI: wide = {1'b0, b};
            OP_AND:  wide = {1'b0, a & b};
            OP_OR:   wide = {1'b0, a | b};
            OP_XOR:  wide = {1'b0, a ^ b};
            default: wide = '0;
        endcase
        y = wide[W-1:0];
        flags[FLG_Z] = ~|wide[W-1:0];
        flags[FLG_C] = cy;
        flags[FLG_S] = wide[MSB];
        flags[FLG_O] = ov;
    end

endmodule

// File: rtl/acc_decode.sv
module acc_decode
    import acc_cpu_pkg::*;
#(
    parameter int IW  = 12,
    parameter int DAW = 4
) (
    input  logic [IW-1:0]   ir,
    input  logic [3:0]      sr,
    output instr_kind_e     kind,
    output alu_op_e         op,
    output logic [7:0]      imm,
    output logic [DAW-1:0]  daddr,
    output logic            take
);
    logic flag_sel;

    always_comb begin
        // priority: bit 11 over bit 10 over bit 9
        if (ir[11])      kind = K_ALU;
        else if (ir[10]) kind = K_JUMP;
        else if (ir[9])  kind = ir[8] ? K_STORE : K_LOAD;
        else             kind = K_NOP;

        op    = alu_op_e'(ir[10:8]);
        imm   = ir[7:0];
        daddr = ir[DAW-1:0];

        unique case (ir[9:8])
            2'b00:   flag_sel = sr[FLG_Z];
            2'b01:   flag_sel = sr[FLG_C];
            2'b10:   flag_sel = sr[FLG_S];
            default: flag_sel = sr[FLG_O];
        endcase
        take = (kind == K_JUMP) && flag_sel;
    end

endmodule

// File: rtl/acc_ram.sv
module acc_ram #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int PMEM_DEPTH = 256,
    parameter int DMEM_DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         load_we,
    input  logic [7:0]   load_addr,
    input  logic [11:0]  load_data,
    output logic [1:0]   dbg_state,
    output logic [7:0]   dbg_pc,
    output logic [7:0]   dbg_acc,
    output logic [3:0]   dbg_sr,
    output logic [7:0]   dbg_dr
);
    localparam int PAW = $clog2(PMEM_DEPTH);
    localparam int DAW = $clog2(DMEM_DEPTH);

    core_regs_t cur_q, nxt_d;

    logic [INSTR_W-1:0] pm_rdata;
    logic               pm_we;
    logic [DATA_W-1:0]  dm_rdata;
    logic               dm_we;

    instr_kind_e        dec_kind;
    alu_op_e            dec_op;
    logic [7:0]         dec_imm;
    logic [DAW-1:0]     dec_daddr;
    logic               dec_take;

    logic [DATA_W-1:0]  alu_y;
    logic [FLAG_W-1:0]  alu_flags;

    logic [INSTR_W-1:0] ir_now;
    assign ir_now = cur_q.ir;

    assign pm_we = (cur_q.st == ST_LOAD) && load_en && load_we;
    assign dm_we = (cur_q.st == ST_EXEC) && (dec_kind == K_STORE);

    acc_ram #(.W(INSTR_W), .DEPTH(PMEM_DEPTH)) i_pmem (
        .clk   (clk),
        .we    (pm_we),
        .waddr (load_addr[PAW-1:0]),
        .wdata (load_data),
        .raddr (cur_q.pc[PAW-1:0]),
        .rdata (pm_rdata)
    );

    acc_ram #(.W(DATA_W), .DEPTH(DMEM_DEPTH)) i_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dec_daddr),
        .wdata (cur_q.acc),
        .raddr (dec_daddr),
        .rdata (dm_rdata)
    );

    acc_decode #(.IW(INSTR_W), .DAW(DAW)) i_dec (
        .ir    (cur_q.ir),
        .sr    (cur_q.sr),
        .kind  (dec_kind),
        .op    (dec_op),
        .imm   (dec_imm),
        .daddr (dec_daddr),
        .take  (dec_take)
    );

    acc_alu #(.W(DATA_W)) i_alu (
        .op    (dec_op),
        .a     (cur_q.acc),
        .b     (dec_imm),
        .y     (alu_y),
        .flags (alu_flags)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_LOAD: begin
                if (!load_en) begin
                    nxt_d.st = ST_FETCH;
                    nxt_d.pc = '0;
                end
            end
            ST_FETCH: begin
                nxt_d.ir = pm_rdata;
                nxt_d.st = ST_DECODE;
            end
            ST_DECODE: begin
                nxt_d.st = ST_EXEC;
            end
            ST_EXEC: begin
                nxt_d.st = ST_FETCH;
                nxt_d.pc = DATA_W'(cur_q.pc + 1'b1);
                unique case (dec_kind)
                    K_ALU: begin
                        nxt_d.acc = alu_y;
                        nxt_d.sr  = alu_flags;
                    end
                    K_JUMP: begin
                        if (dec_take) nxt_d.pc = dec_imm;
                    end
                    K_LOAD: begin
                        nxt_d.dr = dm_rdata;
                    end
                    default: ;
                endcase
            end
            default: nxt_d.st = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st  <= ST_LOAD;
            cur_q.pc  <= '0;
            cur_q.acc <= '0;
            cur_q.dr  <= '0;
            cur_q.sr  <= '0;
            cur_q.ir  <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dbg_state = cur_q.st;
    assign dbg_pc    = cur_q.pc;
    assign dbg_acc   = cur_q.acc;
    assign dbg_sr    = cur_q.sr;
    assign dbg_dr    = cur_q.dr;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        load_en,
    input logic [1:0]  state,
    input logic [7:0]  pc,
    input logic [7:0]  acc,
    input logic [3:0]  sr,
    input logic [7:0]  dr,
    input logic [11:0] ir
);
    logic jflag;
    always_comb jflag = sr[2'd3 - ir[9:8]];

    logic exec;
    assign exec = (state == 2'd3);

    p_load_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0 && load_en) |=> (state == 2'd0));

    p_load_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0 && !load_en) |=> (state == 2'd1 && pc == 8'd0));

    p_fetch_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1) |=> (state == 2'd2));

    p_decode_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2) |=> (state == 2'd3 && $stable(pc) && $stable(acc)));

    p_exec_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> (state == 2'd1));

    p_zs_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && ir[11]) |=> (sr[3] == (acc == 8'd0)) && (sr[1] == acc[7]));

    p_sr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec || !ir[11]) |=> $stable(sr));

    p_jump_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && ir[11:10] == 2'b01) |=>
            (pc == ($past(jflag) ? $past(ir[7:0]) : 8'($past(pc) + 8'd1))));

    p_mem_keeps_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && ir[11:9] == 3'b001) |=> ($stable(acc) && $stable(sr)));

    p_nop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && ir[11:9] == 3'b000) |=>
            (pc == 8'($past(pc) + 8'd1) && $stable(acc) && $stable(dr)));

    p_no_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'd0) |=> (state != 2'd0));

endmodule

bind acc_cpu acc_cpu_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .state   (dbg_state),
    .pc      (dbg_pc),
    .acc     (dbg_acc),
    .sr      (dbg_sr),
    .dr      (dbg_dr),
    .ir      (ir_now)
);

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_en;
    logic        load_we;
    logic [7:0]  load_addr;
    logic [11:0] load_data;
    logic [1:0]  dbg_state;
    logic [7:0]  dbg_pc;
    logic [7:0]  dbg_acc;
    logic [3:0]  dbg_sr;
    logic [7:0]  dbg_dr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    acc_cpu i_acc_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data),
        .dbg_state (dbg_state),
        .dbg_pc    (dbg_pc),
        .dbg_acc   (dbg_acc),
        .dbg_sr    (dbg_sr),
        .dbg_dr    (dbg_dr)
    );

    // {addr, instr, pc after, acc after, sr after, dr after}
    localparam int NV = 28;
    localparam logic [47:0] VECS [NV] = '{
        {8'h00, 12'hB05, 8'h01, 8'h05, 4'h0, 8'h00},
        {8'h01, 12'h87F, 8'h02, 8'h84, 4'h3, 8'h00},
        {8'h02, 12'h710, 8'h10, 8'h84, 4'h3, 8'h00},
        {8'h10, 12'h430, 8'h11, 8'h84, 4'h3, 8'h00},
        {8'h11, 12'h87C, 8'h12, 8'h00, 4'hC, 8'h00},
        {8'h12, 12'h420, 8'h20, 8'h00, 4'hC, 8'h00},
        {8'h20, 12'h524, 8'h24, 8'h00, 4'hC, 8'h00},
        {8'h24, 12'h901, 8'h25, 8'hFF, 4'h6, 8'h00},
        {8'h25, 12'h628, 8'h28, 8'hFF, 4'h6, 8'h00},
        {8'h28, 12'h303, 8'h29, 8'hFF, 4'h6, 8'h00},
        {8'h29, 12'hB80, 8'h2A, 8'h80, 4'h2, 8'h00},
        {8'h2A, 12'hF01, 8'h2B, 8'h81, 4'h7, 8'h00},
        {8'h2B, 12'h203, 8'h2C, 8'h81, 4'h7, 8'hFF},
        {8'h2C, 12'hC0F, 8'h2D, 8'h01, 4'h0, 8'hFF},
        {8'h2D, 12'hDF0, 8'h2E, 8'hF1, 4'h2, 8'hFF},
        {8'h2E, 12'hEF1, 8'h2F, 8'h00, 4'h8, 8'hFF},
        {8'h2F, 12'h500, 8'h30, 8'h00, 4'h8, 8'hFF},
        {8'h30, 12'h600, 8'h31, 8'h00, 4'h8, 8'hFF},
        {8'h31, 12'h700, 8'h32, 8'h00, 4'h8, 8'hFF},
        {8'h32, 12'h000, 8'h33, 8'h00, 4'h8, 8'hFF},
        {8'h33, 12'h105, 8'h34, 8'h00, 4'h8, 8'hFF},
        {8'h34, 12'hA55, 8'h35, 8'h00, 4'h8, 8'hFF},
        {8'h35, 12'h30F, 8'h36, 8'h00, 4'h8, 8'hFF},
        {8'h36, 12'h20F, 8'h37, 8'h00, 4'h8, 8'h00},
        {8'h37, 12'hB7F, 8'h38, 8'h7F, 4'h0, 8'h00},
        {8'h38, 12'h9FF, 8'h39, 8'h80, 4'h7, 8'h00},
        {8'h39, 12'h400, 8'h3A, 8'h80, 4'h7, 8'h00},
        {8'h3A, 12'h880, 8'h3B, 8'h00, 4'hD, 8'h00}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_vec(input int i);
        logic [11:0] ins;
        string rq_acc, rq_sr, rq_pc;
        ins = VECS[i][39:28];
        if (ins[11]) begin
            rq_acc = "R4"; rq_sr = "R5"; rq_pc = "R4";
        end else if (ins[10]) begin
            rq_acc = "R7"; rq_sr = "R6"; rq_pc = "R7";
        end else if (ins[9]) begin
            rq_acc = "R8"; rq_sr = "R6"; rq_pc = "R8";
        end else begin
            rq_acc = "R9"; rq_sr = "R6"; rq_pc = "R9";
        end
        chk("R3", $sformatf("state after word %0d", i), 32'(dbg_state), 32'd1);
        chk(rq_pc,  $sformatf("pc after %03h", ins),  32'(dbg_pc),  32'(VECS[i][27:20]));
        chk(rq_acc, $sformatf("acc after %03h", ins), 32'(dbg_acc), 32'(VECS[i][19:12]));
        chk(rq_sr,  $sformatf("sr after %03h", ins),  32'(dbg_sr),  32'(VECS[i][11:8]));
        chk("R8",   $sformatf("dr after %03h", ins),  32'(dbg_dr),  32'(VECS[i][7:0]));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        rst_n     = 1'b0;
        load_en   = 1'b1;
        load_we   = 1'b0;
        load_addr = '0;
        load_data = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "state in reset", 32'(dbg_state), 32'd0);
        chk("R1", "pc in reset",    32'(dbg_pc),    32'd0);
        chk("R1", "acc in reset",   32'(dbg_acc),   32'd0);
        chk("R1", "sr in reset",    32'(dbg_sr),    32'd0);
        chk("R1", "dr in reset",    32'(dbg_dr),    32'd0);
        @(negedge clk) rst_n = 1'b1;

        // R2: program load
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            load_we   = 1'b1;
            load_addr = VECS[i][47:40];
            load_data = VECS[i][39:28];
        end
        @(negedge clk);
        load_addr = 8'h3B;
        load_data = 12'hB42;
        @(posedge clk);
        #1 chk("R2", "stays in load while enabled", 32'(dbg_state), 32'd0);
        @(negedge clk);
        load_we = 1'b0;
        load_en = 1'b0;
        @(posedge clk);
        #1;
        chk("R2", "state after load exit", 32'(dbg_state), 32'd1);
        chk("R2", "pc after load exit",    32'(dbg_pc),    32'd0);

        // R3: stepping through the first instruction
        @(posedge clk);
        #1 chk("R3", "decode follows fetch", 32'(dbg_state), 32'd2);
        @(posedge clk);
        #1;
        chk("R3", "execute follows decode", 32'(dbg_state), 32'd3);
        chk("R3", "acc untouched before execute", 32'(dbg_acc), 32'd0);
        chk("R3", "pc untouched before execute",  32'(dbg_pc),  32'd0);
        @(posedge clk);
        #1 check_vec(0);

        for (int i = 1; i < NV - 1; i++) begin
            repeat (3) @(posedge clk);
            #1 check_vec(i);
        end

        // R10: load port driven during execution of the last trace word
        @(negedge clk);
        load_en   = 1'b1;
        load_we   = 1'b1;
        load_addr = 8'h3B;
        load_data = 12'hB99;
        repeat (3) @(posedge clk);
        #1 check_vec(NV - 1);
        chk("R10", "no return to load", 32'(dbg_state), 32'd1);
        @(negedge clk);
        load_en = 1'b0;
        load_we = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "original word executed (acc)", 32'(dbg_acc), 32'h42);
        chk("R10", "pc after protected word",      32'(dbg_pc),  32'h3C);
        chk("R5",  "sr after move of 42",          32'(dbg_sr),  32'h0);

        // R1: asynchronous reset in the middle of a run
        @(negedge clk);
        load_en = 1'b1;
        rst_n   = 1'b0;
        #1;
        chk("R1", "state after mid-run reset", 32'(dbg_state), 32'd0);
        chk("R1", "pc after mid-run reset",    32'(dbg_pc),    32'd0);
        chk("R1", "acc after mid-run reset",   32'(dbg_acc),   32'd0);
        chk("R1", "sr after mid-run reset",    32'(dbg_sr),    32'd0);
        chk("R1", "dr after mid-run reset",    32'(dbg_dr),    32'd0);
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule